// File: doc/BRIEF.md
# DMA Channel Enable and Completion Control

This block is the control and status core of a single DMA channel. It holds the channel enable bit, the interrupt enable bit, a sticky completion flag and a transfer unit counter. Every cycle it decides whether the channel may move data. When it may, it sends a one-cycle strobe to the data path for each unit that is to be transferred. It counts those units down and raises the completion flag when the count runs out.

The channel can run in two request modes. In auto mode it issues a unit every cycle for as long as it is allowed to run. In request mode it issues one unit for each rising edge of an external request line, but only for edges that arrive while the channel is allowed to run. A global master enable, a global NMI flag, a per-cycle address-error input and the channel's own enable bit can each stop a transfer early. None of them raises the completion flag. Software clears the completion flag with a read-then-write-zero handshake. While the flag is set, the channel stays blocked even if its enable bit is 1.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the enable bit, interrupt enable bit and completion flag are 0. `irq` and `xfer_stb` are 0, and the control register reads 0.
- R2: `xfer_stb` is asserted only while all of these hold: the enable bit is 1, the completion flag is 0, `glb_enable` is 1, `glb_nmi` is 0 and `addr_err` is 0.
- R3: With `req_mode` = 0 (auto), the channel strobes in every cycle in which it may run and the count is nonzero. Each strobe lowers the count register (address 1) by one.
- R4: With `req_mode` = 1 (request), each rising edge of `ext_req` seen while the channel may run gives exactly one strobe. A request line that was already high before the channel could run gives no strobe.
- R5: The completion flag sets on the clock edge that ends the strobe taking the count from 1 to 0. No strobe is issued while the count is 0.
- R6: A transfer stopped by `addr_err`, `glb_nmi`, `glb_enable` low or a write of 0 to the enable bit leaves the completion flag at 0 and keeps the remaining count. `addr_err` also clears the enable bit.
- R7: `irq` is high exactly while both the completion flag and the interrupt enable bit are 1.
- R8: A write to the control register with bit 1 = 0 clears the completion flag only if that register was read with the flag at 1 since the last control write. A write with bit 1 = 1 never changes the flag, and it cancels a pending read.
- R9: While the completion flag is 1, writing the enable bit to 1 gives no strobes.
- R10: A write to the count register in the same cycle as a strobe loads the written value and skips that strobe's decrement.

Control register (address 0): bit 0 is the enable bit, bit 1 is the completion flag, bit 2 is the interrupt enable. Count register: address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (arms the flag clear) |
| reg_addr | input | 2 | Register address: 0 control, 1 count |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| req_mode | input | 1 | 0 auto request, 1 external/peripheral request |
| ext_req | input | 1 | External request line, used on its rising edge |
| glb_enable | input | 1 | Global master enable |
| glb_nmi | input | 1 | Global NMI flag |
| addr_err | input | 1 | Address error, aborts the channel |
| xfer_stb | output | 1 | One strobe per transfer unit to the data path |
| irq | output | 1 | Level completion interrupt |
| chan_en | output | 1 | Enable bit state |
| end_flag | output | 1 | Completion flag state |

## Verification
The assertions take for granted that `reg_we` and `reg_re` are never high together for the control register, and that `ext_req` stays low for at least one cycle between requests. Without that low cycle the one-strobe-per-edge property would not apply. The stimulus drives every input once per cycle, away from the active edge, and always raises a read and a write in separate cycles. Request pulses are one cycle high followed by a random number of low cycles. Aborts are single pulses placed at random or directed points within a running transfer.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT = 2'd1;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_END_BIT = 1;
  localparam int unsigned CTRL_IE_BIT  = 2;

  typedef enum logic {
    REQ_AUTO = 1'b0,
    REQ_EXT  = 1'b1
  } req_mode_e;
endpackage

// File: rtl/dcc_regs.sv
module dcc_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic ctrl_re,
  input  logic wr_en_bit,
  input  logic wr_end_bit,
  input  logic wr_ie_bit,
  input  logic addr_err,
  input  logic unit_last,
  output logic chan_en,
  output logic end_flag,
  output logic int_en,
  output logic irq
);
  logic en_q, en_d;
  logic ie_q, ie_d;
  logic end_q, end_d;
  logic arm_q, arm_d;

  always_comb begin
    en_d = en_q;
    if (ctrl_we) en_d = wr_en_bit;
    if (addr_err) en_d = 1'b0;

    ie_d = ie_q;
    if (ctrl_we) ie_d = wr_ie_bit;

    arm_d = arm_q;
    if (ctrl_re && end_q) arm_d = 1'b1;
    if (ctrl_we || unit_last) arm_d = 1'b0;

    end_d = end_q;
    if (ctrl_we && !wr_end_bit && arm_q) end_d = 1'b0;
    if (unit_last) end_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
      end_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ie_q  <= ie_d;
      end_q <= end_d;
      arm_q <= arm_d;
    end
  end

  assign chan_en  = en_q;
  assign end_flag = end_q;
  assign int_en   = ie_q;
  assign irq      = end_q & ie_q;

  // R5 / R6: the flag rises only when the last unit completes
  a_r5_end_from_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_q) |-> $past(unit_last));

  // R6: an address error leaves the channel disabled
  a_r6_err_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> !en_q);

  // R8: a write with bit 1 set never clears the flag
  a_r8_one_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && ctrl_we && wr_end_bit) |=> end_q);
endmodule

// File: rtl/dcc_count.sv
module dcc_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             stb,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_nz,
  output logic             unit_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = cnt_we | stb;
    cnt_d  = cnt_q;
    if (cnt_we)   cnt_d = cnt_wdata;
    else if (stb) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt       = cnt_q;
  assign cnt_nz    = |cnt_q;
  assign unit_last = stb & (cnt_q == ONE) & ~cnt_we;

  // R5: no strobe reaches the counter at zero
  a_r5_no_stb_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !stb);

  // R3: each plain strobe removes exactly one unit
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !cnt_we) |=> (cnt_q == $past(cnt_q) - ONE));

  // R10: a register write wins over a decrement
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));
endmodule

// File: rtl/dcc_gate.sv
module dcc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic end_flag,
  input  logic glb_enable,
  input  logic glb_nmi,
  input  logic addr_err,
  input  logic req_mode,
  input  logic ext_req,
  input  logic cnt_nz,
  output logic stb
);
  import dcc_pkg::*;

  logic ext_q;
  logic active;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_req;
  end

  always_comb begin
    active = chan_en & ~end_flag & glb_enable & ~glb_nmi & ~addr_err;
    rise   = ext_req & ~ext_q;
    stb    = active & cnt_nz & ((req_mode == REQ_AUTO) | rise);
  end

  // R2: strobes only while every gating condition is met
  a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (chan_en && !end_flag && glb_enable && !glb_nmi && !addr_err));

  // R4: in request mode a strobe needs a fresh edge on the request line
  a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && req_mode == REQ_EXT) |-> (ext_req && !$past(ext_req)));

  // R4: never two request-mode strobes back to back
  a_r4_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && req_mode == REQ_EXT) |=> !(stb && req_mode == REQ_EXT));
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_mode,
  input  logic              ext_req,
  input  logic              glb_enable,
  input  logic              glb_nmi,
  input  logic              addr_err,
  output logic              xfer_stb,
  output logic              irq,
  output logic              chan_en,
  output logic              end_flag
);
  import dcc_pkg::*;

  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic             ctrl_we, ctrl_re, cnt_we;
  logic             int_en;
  logic             unit_last, cnt_nz, stb;
  logic [CNT_W-1:0] cnt;

  assign ctrl_we = reg_we & (reg_addr == ADDR_CTRL);
  assign ctrl_re = reg_re & (reg_addr == ADDR_CTRL);
  assign cnt_we  = reg_we & (reg_addr == ADDR_COUNT);

  dcc_regs regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_re    (ctrl_re),
    .wr_en_bit  (reg_wdata[CTRL_EN_BIT]),
    .wr_end_bit (reg_wdata[CTRL_END_BIT]),
    .wr_ie_bit  (reg_wdata[CTRL_IE_BIT]),
    .addr_err   (addr_err),
    .unit_last  (unit_last),
    .chan_en    (chan_en),
    .end_flag   (end_flag),
    .int_en     (int_en),
    .irq        (irq)
  );

  dcc_count #(.CNT_W(CNT_W)) count_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (cnt_we),
    .cnt_wdata (reg_wdata[CNT_W-1:0]),
    .stb       (stb),
    .cnt       (cnt),
    .cnt_nz    (cnt_nz),
    .unit_last (unit_last)
  );

  dcc_gate gate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .end_flag   (end_flag),
    .glb_enable (glb_enable),
    .glb_nmi    (glb_nmi),
    .addr_err   (addr_err),
    .req_mode   (req_mode),
    .ext_req    (ext_req),
    .cnt_nz     (cnt_nz),
    .stb        (stb)
  );

  assign xfer_stb = stb;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_EN_BIT]  = chan_en;
        reg_rdata[CTRL_END_BIT] = end_flag;
        reg_rdata[CTRL_IE_BIT]  = int_en;
      end
      ADDR_COUNT: reg_rdata = {{PAD_W{1'b0}}, cnt};
      default:    reg_rdata = '0;
    endcase
  end

  // R9: a set completion flag blocks the channel
  a_r9_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> !xfer_stb);

  // R7: the interrupt never appears without the completion flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> end_flag);
endmodule

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              req_mode = 1'b0, ext_req = 1'b0;
  logic              glb_enable = 1'b1, glb_nmi = 1'b0, addr_err = 1'b0;
  logic              xfer_stb, irq, chan_en, end_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int nstb     = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_chan_ctl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_mode(req_mode), .ext_req(ext_req), .glb_enable(glb_enable),
    .glb_nmi(glb_nmi), .addr_err(addr_err), .xfer_stb(xfer_stb),
    .irq(irq), .chan_en(chan_en), .end_flag(end_flag)
  );

  always @(negedge clk) begin
    #2;
    if (xfer_stb === 1'b1) nstb++;
  end

  function automatic logic exp_irq(input logic flag, input logic ie);
    return flag & ie;
  endfunction

  function automatic int exp_left(input int start, input int done);
    return start - done;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_flag(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      #1;
      if (end_flag) break;
    end
    cycles(2);
  endtask

  task automatic pulse(input int gap);
    @(negedge clk); ext_req = 1'b1;
    @(negedge clk); ext_req = 1'b0;
    cycles(gap);
  endtask

  task automatic clear_flag(input logic [DATA_W-1:0] ctrl);
    logic [DATA_W-1:0] d;
    rd(2'd0, d);
    wr(2'd0, ctrl);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    int n1, ntot;
    void'($urandom(32'h5eed_1234));

    cycles(3);
    #1;
    check("R1 chan_en", chan_en, 0);
    check("R1 end_flag", end_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 xfer_stb", xfer_stb, 0);
    rd(2'd0, d);
    check("R1 ctrl read", d, 0);
    @(negedge clk) rst_n = 1'b1;
    cycles(2);
    rd(2'd0, d);
    check("R1 ctrl after release", d, 0);

    // R2 gating, then R3 / R5 / R7 in auto mode
    glb_enable = 1'b0;
    wr(2'd1, 5);
    wr(2'd0, 32'h5);
    nstb = 0;
    cycles(3);
    check("R2 master disable", nstb, 0);
    @(negedge clk); glb_enable = 1'b1; glb_nmi = 1'b1;
    cycles(3);
    check("R2 nmi flag", nstb, 0);
    @(negedge clk); glb_nmi = 1'b0;
    wait_flag(50);
    cycles(3);
    check("R3 auto unit count", nstb, 5);
    check("R5 flag set", end_flag, 1);
    check("R7 irq with ie", irq, exp_irq(end_flag, 1'b1));
    rd(2'd1, d);
    check("R3 count drained", d, 0);

    // R8 clear protocol, R9 flag blocks
    wr(2'd0, 32'h5);
    #1 check("R8 write0 without read", end_flag, 1);
    rd(2'd0, d);
    wr(2'd0, 32'h7);
    #1 check("R8 write1 no effect", end_flag, 1);
    wr(2'd0, 32'h5);
    #1 check("R8 write1 cancels arm", end_flag, 1);
    wr(2'd1, 3);
    nstb = 0;
    wr(2'd0, 32'h5);
    cycles(4);
    check("R9 flag blocks enable", nstb, 0);
    check("R7 irq held", irq, 1);
    clear_flag(32'h5);
    #1 check("R8 read then write0 clears", end_flag, 0);
    wait_flag(50);
    check("R9 runs after clear", nstb, 3);

    // R4 request mode
    clear_flag(32'h0);
    #1 check("R7 irq drops", irq, 0);
    req_mode = 1'b1;
    wr(2'd1, 4);
    pulse(1);
    @(negedge clk); ext_req = 1'b1;
    nstb = 0;
    wr(2'd0, 32'h1);
    cycles(4);
    check("R4 stale level ignored", nstb, 0);
    @(negedge clk); ext_req = 1'b0;
    for (int i = 0; i < 4; i++) pulse(i);
    cycles(3);
    check("R4 one strobe per edge", nstb, 4);
    check("R5 flag after requests", end_flag, 1);
    check("R7 irq without ie", irq, 0);

    // R6 aborts
    req_mode = 1'b0;
    clear_flag(32'h0);
    wr(2'd1, 20);
    nstb = 0;
    wr(2'd0, 32'h1);
    cycles(3);
    @(negedge clk); addr_err = 1'b1;
    @(negedge clk); addr_err = 1'b0;
    cycles(3);
    ntot = nstb;
    check("R6 err clears enable", chan_en, 0);
    check("R6 err no flag", end_flag, 0);
    rd(2'd1, d);
    check("R6 err keeps count", d, exp_left(20, ntot));
    wr(2'd0, 32'h1);
    cycles(2);
    @(negedge clk); glb_nmi = 1'b1;
    n1 = nstb;
    cycles(3);
    check("R6 nmi halts", nstb, n1);
    check("R6 nmi no flag", end_flag, 0);
    @(negedge clk); glb_nmi = 1'b0;
    cycles(1);
    wr(2'd0, 32'h0);
    cycles(3);
    check("R6 disable no flag", end_flag, 0);
    rd(2'd1, d);
    check("R6 disable keeps count", d, exp_left(20, nstb));

    // R10 write vs strobe
    wr(2'd1, 100);
    wr(2'd0, 32'h1);
    cycles(5);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 2;
    #3 nstb = 0;
    @(negedge clk); reg_we = 1'b0;
    wait_flag(50);
    check("R10 write wins", nstb, 2);

    // random trials
    for (int t = 0; t < 40; t++) begin
      int n;
      logic ie, md;
      n  = 1 + int'($urandom_range(11));
      ie = 1'($urandom_range(1));
      md = 1'($urandom_range(1));
      clear_flag(32'h0);
      req_mode = md;
      wr(2'd1, n);
      nstb = 0;
      wr(2'd0, {29'd0, ie, 1'b0, 1'b1});
      if (md) for (int k = 0; k < n; k++) pulse(int'($urandom_range(3)));
      else    wait_flag(40);
      cycles(3);
      check(md ? "R4 random units" : "R3 random units", nstb, n);
      check("R5 random flag", end_flag, 1);
      check("R7 random irq", irq, exp_irq(end_flag, ie));
    end

    finished = 1'b1;
    summary();
  end
endmodule